// File: doc/BRIEF.md
# Staged Trim Register Bank with Atomic Apply

This block holds the trim codes that steer a multiphase voltage regulator: an output setpoint code, a droop-slope code, a current-limit threshold code and a phase-share offset code. Each code exists twice. The staging copy is written through a valid/ready write port. The live copy drives the converter and changes only when a commit is applied. Every staged value is checked before it is taken: the field index must exist, the value must lie inside that field's window, and the two protected fields need the unlock level.

A host opens a transaction with a start pulse, writes any subset of fields, and then pulses commit. The commit is taken only if the transaction is clean. A refused commit restores both copies from the last validated set. In stepped mode the live codes walk toward their new targets in bounded increments, and the bank stays busy until every field arrives. A commit counter lets the host confirm that an apply happened. The readback port returns either copy of any field.

Write port back-pressure: a write is taken only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the bank is stepping. The host must hold the write until it sees a handshake.

Top module: `trim_commit_bank`

## Requirements
- R1: After reset, both copies of field i hold the midpoint code (lo_i+hi_i)/2, the counter is 0, `busy` is 0 and `wr_ready` is 1. The window bounds for W-bit fields are lo_i = 2^(W-5) + i*2^(W-6) and hi_i = 2^W - (i+1)*2^(W-4). Field 0 is the setpoint, 1 the droop slope, 2 the current limit and 3 the share offset.
- R2: An accepted write changes only the staging copy. The live output `active_flat` (field i in bits [i*W +: W]) is unchanged until a commit is taken.
- R3: A write whose value lies outside [lo_i, hi_i] is rejected. The staging copy keeps its old value and the transaction is marked failed. Live codes always stay inside their windows.
- R4: Fields 1 and 2 accept writes only while `unlock` is 1. Otherwise the write is rejected and the transaction is marked failed.
- R5: A commit on a clean transaction is taken. A clean transaction has at least one write since the start pulse, no rejected write and no `bus_err`. With `soft_en` low, every live field takes its staging value on the same clock edge, and the counter increments by one.
- R6: A commit on a transaction that is not clean (including an empty one) is refused. Staging and live copies revert to the last validated set, and the counter is unchanged.
- R7: With `soft_en` high at the commit, each live field moves toward its target by at most STEP_MAX once every `step_intv` clocks (0 counts as 1). `busy` stays high until all fields are equal to their targets.
- R8: While `busy` is high, `wr_ready` is 0 and commit pulses are ignored.
- R9: Repeating the same accepted write leaves the same staging value. Repeating an identical transaction leaves the same live state.
- R10: The commit counter never decreases and steps by exactly one for each commit that is taken.
- R11: The readback returns the live copy when `rb_active` is 1 and the staging copy when it is 0. A field index of NUM_FIELDS or higher reads 0.
- R12: A write to a field index of NUM_FIELDS or higher is rejected and marks the transaction failed.
- R13: A start pulse clears the previous transaction's failure state and write mask. A commit clears them as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_start | input | 1 | Opens a new staging transaction |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be taken (low while stepping) |
| wr_field | input | FIDX_W | Field index of the write |
| wr_data | input | FIELD_W | Code to stage |
| unlock | input | 1 | Permits writes to protected fields |
| bus_err | input | 1 | Transport error reported in this transaction |
| commit | input | 1 | Apply request |
| soft_en | input | 1 | Step toward targets instead of jumping |
| step_intv | input | STEP_DIV_W | Clocks between steps |
| rb_field | input | FIDX_W | Readback field index |
| rb_active | input | 1 | 1 selects the live copy, 0 the staging copy |
| rb_data | output | FIELD_W | Readback value |
| active_flat | output | NUM_FIELDS*FIELD_W | Live codes of all fields |
| busy | output | 1 | Stepping in progress |
| commit_cnt | output | CNT_W | Count of commits taken |

## Verification
A corrupted write mask or a stale failure flag shows up at the first commit after it. That commit is either taken when it should be refused or refused when it should be taken, and the counter and `active_flat` differ on the next clock. A wrong staging or last-good value is visible at once through the staging readback, and after the next refused commit through the live codes. A stepping fault appears within one step interval as a live code that moves too far, moves too early, or leaves `busy` set after arrival. The bench compares every output against a behavioural model on every clock, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;

  // Per-field allowed window, derived from the field width and index.
  function automatic int win_lo(int w, int i);
    return (1 << (w - 5)) + i * (1 << (w - 6));
  endfunction

  function automatic int win_hi(int w, int i);
    return (1 << w) - (i + 1) * (1 << (w - 4));
  endfunction

  function automatic int win_mid(int w, int i);
    return (win_lo(w, i) + win_hi(w, i)) / 2;
  endfunction

  // Droop-slope and current-limit positions need the unlock level.
  function automatic bit needs_unlock(int i);
    return (i % 4 == 1) || (i % 4 == 2);
  endfunction

endpackage

// File: rtl/trim_write_check.sv
module trim_write_check
  import trim_bank_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 10,
  parameter int FIDX_W     = 3
) (
  input  logic [FIDX_W-1:0]  field,
  input  logic [FIELD_W-1:0] data,
  input  logic               unlock,
  output logic               idx_ok,
  output logic               pass
);

  always_comb begin
    idx_ok = 1'b0;
    pass   = 1'b0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (field == FIDX_W'(i)) begin
        idx_ok = 1'b1;
        pass   = (data >= FIELD_W'(win_lo(FIELD_W, i))) &&
                 (data <= FIELD_W'(win_hi(FIELD_W, i))) &&
                 (unlock || !needs_unlock(i));
      end
    end
  end

endmodule

// File: rtl/trim_txn_tracker.sv
module trim_txn_tracker #(
  parameter int NUM_FIELDS = 4,
  parameter int FIDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_start,
  input  logic              bus_err,
  input  logic              wr_fire,
  input  logic [FIDX_W-1:0] wr_field,
  input  logic              wr_idx_ok,
  input  logic              wr_pass,
  input  logic              commit_req,
  output logic              commit_accept,
  output logic              commit_refuse
);

  logic [NUM_FIELDS-1:0] touched_q;
  logic [NUM_FIELDS-1:0] good_q;
  logic                  fail_q;
  logic                  clean;

  assign clean         = !fail_q && (|touched_q) && ((touched_q & ~good_q) == '0);
  assign commit_accept = commit_req && clean;
  assign commit_refuse = commit_req && !clean;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched_q <= '0;
      good_q    <= '0;
      fail_q    <= 1'b0;
    end else begin
      if (commit_req || stage_start) begin
        touched_q <= '0;
        good_q    <= '0;
        fail_q    <= 1'b0;
      end
      if (bus_err) fail_q <= 1'b1;
      if (wr_fire) begin
        if (!wr_idx_ok || !wr_pass) fail_q <= 1'b1;
        for (int i = 0; i < NUM_FIELDS; i++) begin
          if (wr_idx_ok && wr_field == FIDX_W'(i)) begin
            touched_q[i] <= 1'b1;
            good_q[i]    <= wr_pass;
          end
        end
      end
    end
  end

  // A transport error always spoils the transaction it lands in.
  assert_err_blocks_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !commit_accept);

  // A rejected write always spoils the transaction it lands in.
  assert_bad_write_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_pass) |=> !commit_accept);

endmodule

// File: rtl/trim_step_lane.sv
module trim_step_lane #(
  parameter int                 FIELD_W  = 10,
  parameter int                 STEP_MAX = 8,
  parameter logic [FIELD_W-1:0] RST_VAL  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] load_val,
  input  logic [FIELD_W-1:0] target,
  input  logic               tick,
  output logic [FIELD_W-1:0] act,
  output logic               at_target
);

  localparam logic [FIELD_W-1:0] STEP = FIELD_W'(STEP_MAX);

  logic               up;
  logic [FIELD_W-1:0] gap;

  assign up        = target > act;
  assign gap       = up ? (target - act) : (act - target);
  assign at_target = (act == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= RST_VAL;
    end else if (load) begin
      act <= load_val;
    end else if (tick && !at_target) begin
      if (gap <= STEP) act <= target;
      else if (up)     act <= act + STEP;
      else             act <= act - STEP;
    end
  end

  assert_step_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (((act >= $past(act)) ? (act - $past(act)) : ($past(act) - act)) <= STEP));

  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(act));

endmodule

// File: rtl/trim_commit_bank.sv
module trim_commit_bank
  import trim_bank_pkg::*;
#(
  parameter  int NUM_FIELDS = 4,
  parameter  int FIELD_W    = 10,
  parameter  int STEP_MAX   = 8,
  parameter  int STEP_DIV_W = 8,
  parameter  int CNT_W      = 16,
  localparam int FIDX_W     = $clog2(NUM_FIELDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stage_start,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [FIDX_W-1:0]             wr_field,
  input  logic [FIELD_W-1:0]            wr_data,
  input  logic                          unlock,
  input  logic                          bus_err,
  input  logic                          commit,
  input  logic                          soft_en,
  input  logic [STEP_DIV_W-1:0]         step_intv,
  input  logic [FIDX_W-1:0]             rb_field,
  input  logic                          rb_active,
  output logic [FIELD_W-1:0]            rb_data,
  output logic [NUM_FIELDS*FIELD_W-1:0] active_flat,
  output logic                          busy,
  output logic [CNT_W-1:0]              commit_cnt
);

  logic [FIELD_W-1:0]    shadow_q [NUM_FIELDS];
  logic [FIELD_W-1:0]    target_q [NUM_FIELDS];
  logic [FIELD_W-1:0]    lkg_q    [NUM_FIELDS];
  logic [FIELD_W-1:0]    act      [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] at_tgt;

  logic                  wr_fire, wr_idx_ok, wr_pass;
  logic                  commit_req, commit_accept, commit_refuse;
  logic                  lane_load, tick;
  logic [STEP_DIV_W-1:0] div_q, div_last;

  assign busy       = ~&at_tgt;
  assign wr_ready   = ~busy;
  assign wr_fire    = wr_valid && wr_ready;
  assign commit_req = commit && !busy;
  assign lane_load  = commit_refuse || (commit_accept && !soft_en);

  trim_write_check #(
    .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .FIDX_W(FIDX_W)
  ) check_i (
    .field(wr_field), .data(wr_data), .unlock(unlock),
    .idx_ok(wr_idx_ok), .pass(wr_pass)
  );

  trim_txn_tracker #(
    .NUM_FIELDS(NUM_FIELDS), .FIDX_W(FIDX_W)
  ) txn_i (
    .clk(clk), .rst_n(rst_n), .stage_start(stage_start), .bus_err(bus_err),
    .wr_fire(wr_fire), .wr_field(wr_field), .wr_idx_ok(wr_idx_ok),
    .wr_pass(wr_pass), .commit_req(commit_req),
    .commit_accept(commit_accept), .commit_refuse(commit_refuse)
  );

  // Step pacing: one tick every step_intv clocks while stepping.
  assign div_last = (step_intv == '0) ? '0 : step_intv - 1'b1;
  assign tick     = busy && (div_q == div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (commit_accept) div_q <= '0;
    else if (busy)          div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             commit_cnt <= '0;
    else if (commit_accept) commit_cnt <= commit_cnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [FIELD_W-1:0] MID = FIELD_W'(win_mid(FIELD_W, i));
    localparam logic [FIELD_W-1:0] LO  = FIELD_W'(win_lo(FIELD_W, i));
    localparam logic [FIELD_W-1:0] HI  = FIELD_W'(win_hi(FIELD_W, i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= MID;
        target_q[i] <= MID;
        lkg_q[i]    <= MID;
      end else begin
        if (commit_accept) begin
          target_q[i] <= shadow_q[i];
          lkg_q[i]    <= shadow_q[i];
        end else if (commit_refuse) begin
          target_q[i] <= lkg_q[i];
          shadow_q[i] <= lkg_q[i];
        end
        if (wr_fire && wr_pass && wr_field == FIDX_W'(i)) shadow_q[i] <= wr_data;
      end
    end

    trim_step_lane #(
      .FIELD_W(FIELD_W), .STEP_MAX(STEP_MAX), .RST_VAL(MID)
    ) lane_i (
      .clk(clk), .rst_n(rst_n), .load(lane_load),
      .load_val(commit_refuse ? lkg_q[i] : shadow_q[i]),
      .target(target_q[i]), .tick(tick),
      .act(act[i]), .at_target(at_tgt[i])
    );

    assign active_flat[i*FIELD_W +: FIELD_W] = act[i];

    assert_active_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act[i] >= LO) && (act[i] <= HI));
  end

  always_comb begin
    rb_data = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rb_field == FIDX_W'(i)) rb_data = rb_active ? act[i] : shadow_q[i];
    end
  end

  assert_live_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_accept && !commit_refuse && !busy) |=> $stable(active_flat));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_accept |=> (commit_cnt == $past(commit_cnt) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_accept |=> $stable(commit_cnt));

  assert_busy_ignores_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && commit) |=> $stable(commit_cnt));

endmodule

// File: tb/trim_commit_bank_tb_top.sv
`timescale 1ns/1ps
module trim_commit_bank_tb_top;

  localparam int NF = 4;
  localparam int W  = 10;
  localparam int SM = 8;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stage_start = 0, wr_valid = 0, unlock = 0, bus_err = 0, commit = 0, soft_en = 0;
  logic [FW-1:0] wr_field = '0, rb_field = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rb_active = 0;
  logic [7:0]    step_intv = 8'd1;
  logic          wr_ready, busy;
  logic [W-1:0]  rb_data;
  logic [NF*W-1:0] active_flat;
  logic [15:0]   commit_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  trim_commit_bank dut_i (
    .clk(clk), .rst_n(rst_n), .stage_start(stage_start), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_field(wr_field), .wr_data(wr_data), .unlock(unlock),
    .bus_err(bus_err), .commit(commit), .soft_en(soft_en), .step_intv(step_intv),
    .rb_field(rb_field), .rb_active(rb_active), .rb_data(rb_data),
    .active_flat(active_flat), .busy(busy), .commit_cnt(commit_cnt)
  );

  // ---------------- behavioural reference ----------------
  function automatic int lo_of(int i); return 32 + 16 * i; endfunction
  function automatic int hi_of(int i); return 960 - 64 * i; endfunction
  function automatic int mid_of(int i); return (lo_of(i) + hi_of(i)) / 2; endfunction

  int m_sh[NF], m_act[NF], m_tgt[NF], m_lkg[NF];
  bit m_wr[NF], m_ok[NF];
  bit m_err;
  int m_cnt, m_div;

  function automatic bit m_busy();
    for (int i = 0; i < NF; i++) if (m_act[i] != m_tgt[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        m_sh[i] = mid_of(i); m_act[i] = mid_of(i); m_tgt[i] = mid_of(i); m_lkg[i] = mid_of(i);
        m_wr[i] = 0; m_ok[i] = 0;
      end
      m_err = 0; m_cnt = 0; m_div = 0;
    end else begin
      bit bz, clean, anyw, fire, idxok, pass;
      int pre_sh[NF];
      int last, f;
      bz = m_busy();
      for (int i = 0; i < NF; i++) pre_sh[i] = m_sh[i];
      if (commit && !bz) begin
        anyw = 0; clean = !m_err;
        for (int i = 0; i < NF; i++) begin
          if (m_wr[i]) anyw = 1;
          if (m_wr[i] && !m_ok[i]) clean = 0;
        end
        clean = clean && anyw;
        if (clean) begin
          for (int i = 0; i < NF; i++) begin
            m_tgt[i] = pre_sh[i]; m_lkg[i] = pre_sh[i];
            if (!soft_en) m_act[i] = pre_sh[i];
          end
          m_cnt++; m_div = 0;
        end else begin
          for (int i = 0; i < NF; i++) begin
            m_sh[i] = m_lkg[i]; m_act[i] = m_lkg[i]; m_tgt[i] = m_lkg[i];
          end
        end
        for (int i = 0; i < NF; i++) begin m_wr[i] = 0; m_ok[i] = 0; end
        m_err = 0;
      end else if (stage_start) begin
        for (int i = 0; i < NF; i++) begin m_wr[i] = 0; m_ok[i] = 0; end
        m_err = 0;
      end
      if (bz) begin
        last = (step_intv == 0) ? 0 : int'(step_intv) - 1;
        if (m_div == last) begin
          for (int i = 0; i < NF; i++) begin
            if (m_tgt[i] - m_act[i] > SM)       m_act[i] += SM;
            else if (m_act[i] - m_tgt[i] > SM)  m_act[i] -= SM;
            else                                m_act[i] = m_tgt[i];
          end
          m_div = 0;
        end else m_div++;
      end
      if (bus_err) m_err = 1;
      fire = wr_valid && !bz;
      if (fire) begin
        f = int'(wr_field);
        idxok = f < NF;
        pass = idxok && int'(wr_data) >= lo_of(f) && int'(wr_data) <= hi_of(f) &&
               (unlock || !(f == 1 || f == 2));
        if (!pass) m_err = 1;
        if (idxok) begin m_wr[f] = 1; m_ok[f] = pass; end
        if (pass) m_sh[f] = int'(wr_data);
      end
    end
  end

  task automatic chk(string tag, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int rbm;
      for (int i = 0; i < NF; i++) chk("R5 live code", int'(active_flat[i*W +: W]), m_act[i]);
      chk("R7 busy", int'(busy), int'(m_busy()));
      chk("R8 wr_ready", int'(wr_ready), int'(!m_busy()));
      chk("R10 commit count", int'(commit_cnt), m_cnt);
      rbm = (int'(rb_field) < NF) ? (rb_active ? m_act[rb_field] : m_sh[rb_field]) : 0;
      chk("R11 readback", int'(rb_data), rbm);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_start();
    @(posedge clk); #1 stage_start = 1;
    @(posedge clk); #1 stage_start = 0;
  endtask
  task automatic pulse_commit();
    @(posedge clk); #1 commit = 1;
    @(posedge clk); #1 commit = 0;
  endtask
  task automatic pulse_err();
    @(posedge clk); #1 bus_err = 1;
    @(posedge clk); #1 bus_err = 0;
  endtask
  task automatic wr(int f, int d);
    @(posedge clk); #1 wr_valid = 1; wr_field = FW'(f); wr_data = W'(d);
    @(posedge clk); #1 wr_valid = 0;
  endtask
  task automatic expect_rb(string tag, int f, bit sel, int expected);
    @(posedge clk); #1 rb_field = FW'(f); rb_active = sel;
    @(negedge clk);
    chk(tag, int'(rb_data), expected);
  endtask
  task automatic expect_live(string tag, int f, int expected);
    @(negedge clk);
    chk(tag, int'(active_flat[f*W +: W]), expected);
  endtask
  task automatic expect_cnt(string tag, int expected);
    @(negedge clk);
    chk(tag, int'(commit_cnt), expected);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int i = 0; i < NF; i++) expect_live("R1 reset live", i, mid_of(i));
    for (int i = 0; i < NF; i++) expect_rb("R1 reset staging", i, 0, mid_of(i));
    expect_cnt("R1 reset count", 0);
    @(negedge clk); chk("R1 reset busy", int'(busy), 0); chk("R1 reset ready", int'(wr_ready), 1);

    // R2 / R5 direct commit of two fields
    pulse_start();
    wr(0, 500); wr(3, 400);
    expect_live("R2 live unchanged before commit", 0, 496);
    expect_rb("R2 staging updated", 0, 0, 500);
    pulse_commit();
    expect_live("R5 field0 applied", 0, 500);
    expect_live("R5 field3 applied", 3, 400);
    expect_cnt("R5 count after apply", 1);

    // R4 protected field while locked, then unlocked
    pulse_start();
    wr(1, 600);
    expect_rb("R4 locked write rejected", 1, 0, 472);
    pulse_commit();
    expect_cnt("R6 refused after locked write", 1);
    unlock = 1;
    pulse_start();
    wr(1, 600);
    pulse_commit();
    expect_live("R4 unlocked write applied", 1, 600);
    expect_cnt("R4 count", 2);
    unlock = 0;

    // R3 out-of-window write, R6 rollback of staging
    pulse_start();
    wr(2, 900);
    expect_rb("R3 out of window rejected", 2, 0, 448);
    wr(0, 510);
    expect_rb("R3 good write staged", 0, 0, 510);
    pulse_commit();
    expect_rb("R6 staging rolled back", 0, 0, 500);
    expect_live("R6 live kept last good", 0, 500);
    expect_cnt("R6 count held", 2);

    // R6 transport error
    pulse_start();
    wr(0, 520);
    pulse_err();
    pulse_commit();
    expect_live("R6 bus error refused", 0, 500);
    expect_cnt("R6 count held after error", 2);

    // R13 start clears an earlier failure
    pulse_start();
    wr(0, 5);
    pulse_start();
    wr(0, 530);
    pulse_commit();
    expect_live("R13 fresh transaction applied", 0, 530);
    expect_cnt("R13 count", 3);

    // R12 nonexistent field index
    pulse_start();
    wr(5, 100);
    wr(3, 410);
    pulse_commit();
    expect_live("R12 bad index refused", 3, 400);
    expect_cnt("R12 count held", 3);

    // R9 idempotent retry
    pulse_start();
    wr(3, 410); wr(3, 410); wr(3, 410);
    expect_rb("R9 repeated write", 3, 0, 410);
    pulse_commit();
    pulse_start();
    wr(3, 410);
    pulse_commit();
    expect_live("R9 repeated transaction", 3, 410);
    expect_cnt("R9 count", 5);

    // R7 / R8 / R11 stepped apply
    soft_en = 1; step_intv = 8'd3;
    pulse_start();
    wr(0, 600); wr(3, 300);
    expect_rb("R11 staging view", 0, 0, 600);
    expect_rb("R11 live view", 0, 1, 530);
    pulse_commit();
    @(negedge clk); chk("R7 busy after stepped commit", int'(busy), 1);
    chk("R8 ready low while stepping", int'(wr_ready), 0);
    pulse_commit();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    expect_live("R7 field0 reached", 0, 600);
    expect_live("R7 field3 reached", 3, 300);
    expect_cnt("R8 commit while busy ignored", 6);
    soft_en = 0; step_intv = 8'd1;

    // R6 empty transaction, R11 invalid readback index
    pulse_start();
    pulse_commit();
    expect_cnt("R6 empty commit refused", 6);
    expect_rb("R11 invalid index reads zero", 6, 1, 0);

    repeat (4) @(posedge clk);
    summary();
  end

endmodule